// File: doc/BRIEF.md
# Masked Per-Field Video Error Counter

This block sits behind a set of video stream error detectors for one channel. During each field (interlaced) or frame (progressive) it gathers the raw error pulses into a twelve-class error vector. At every interval boundary it does two things: it publishes that vector as a status word, and it adds one to an error counter if any class the channel has enabled was seen. The counter steps at most once per interval, so its rate can never exceed the field or frame rate. An alarm threshold set below the lowest field rate therefore catches any error that persists.

Classes that only mean something in high-definition formats are forced inactive while the channel runs in standard-definition mode. In hold mode, published bits are ORed into the status word until the operator clear. An input that goes silent is detected by a programmable timeout. From then on, an internal tick slightly faster than 60 Hz stands in for the boundary strobe and reports loss of lock on every tick. This keeps the count rising during the outage.

Top module: `vid_err_field_counter`

## Requirements
- R1: Error vector bit positions: 0 no protection flags, 1 unexpected format, 2 full-frame checksum, 3 active-picture checksum, 4 loss of lock, 5 ancillary checksum Y, 6 ancillary checksum C, 7 line CRC Y, 8 line CRC C, 9 line-number sequence, 10 bad start-of-active-video, 11 bad end-of-active-video. A pulse on bit k appears on `err_bits` bit k only.
- R2: While `hd_mode` is 0, pulses on bits 5, 7, 8 and 9 are discarded: they neither reach `err_bits` nor count.
- R3: `count_en` bit k set to 1 makes class k countable. An interval whose errors all sit in classes with `count_en` 0 leaves `err_count` unchanged, although those errors still appear in `err_bits`.
- R4: An interval is closed by a boundary (`field_strobe` or a fallback tick). It covers the cycles after the previous boundary up to and including the closing boundary's cycle. `err_count` rises by exactly 1 one cycle after the boundary if the interval held at least one countable error, however many pulses it held.
- R5: With `hold_en` 0, one cycle after a boundary `err_bits` equals the set of classes seen in the closed interval.
- R6: With `hold_en` 1, one cycle after a boundary `err_bits` becomes its old value ORed with the closed interval's classes.
- R7: `cnt_clear` zeroes `err_count`, `err_bits` and the open interval one cycle later. It wins over a boundary in the same cycle, and that boundary's errors are dropped.
- R8: When `TIMEOUT_CYC` cycles pass with no `field_strobe`, the input is declared lost. From then on a fallback tick closes an interval every `TICK_CYC` cycles, and each tick adds the loss-of-lock class (bit 4) to the closed interval.
- R9: A `field_strobe` ends the lost state, so no fallback tick occurs while strobes keep arriving within the timeout.
- R10: `err_count` (`CNT_W` bits, 32 by default) saturates at all ones instead of wrapping.
- R11: Outside a boundary or clear cycle, `err_bits` and `err_count` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_pulse | input | 12 | Raw error pulses, one bit per class (R1 order) |
| field_strobe | input | 1 | Field or frame boundary strobe |
| hd_mode | input | 1 | 1 = high-definition, 0 = standard-definition |
| count_en | input | 12 | Per-class count enable, 1 = counted |
| hold_en | input | 1 | 1 = accumulate status bits until clear |
| cnt_clear | input | 1 | Operator clear of counter and status |
| err_bits | output | 12 | Published error classes |
| err_count | output | CNT_W | Saturating errored-interval count |

## Verification
Both outputs are registered once after the cycle in which a boundary or clear is sampled. Nothing in between delays them, so each result is due exactly one clock after its stimulus. The fallback tick sits `TIMEOUT_CYC` edges after the last strobe plus whole multiples of `TICK_CYC`. The bench drives inputs on the falling edge and runs a cycle model of the requirements on the rising edge. On every falling edge it compares the outputs with that model, which keeps each comparison in the cycle where the result is due. Directed checks read the outputs one full cycle after the stimulus edge.

// File: rtl/vefc_pkg.sv
package vefc_pkg;
   localparam int unsigned NUM_CLS  = 12;
   localparam int unsigned LOCK_IDX = 4;

   typedef enum int unsigned {
      CLS_NO_PROT   = 0,
      CLS_FORMAT    = 1,
      CLS_FULL_CRC  = 2,
      CLS_ACT_CRC   = 3,
      CLS_LOCK      = 4,
      CLS_ANC_Y     = 5,
      CLS_ANC_C     = 6,
      CLS_LCRC_Y    = 7,
      CLS_LCRC_C    = 8,
      CLS_LINE_NUM  = 9,
      CLS_SAV       = 10,
      CLS_EAV       = 11
   } err_cls_e;

   // classes meaningful only in high-definition formats
   localparam logic [NUM_CLS-1:0] HD_ONLY_MASK =
      (NUM_CLS'(1) << CLS_ANC_Y)  | (NUM_CLS'(1) << CLS_LCRC_Y) |
      (NUM_CLS'(1) << CLS_LCRC_C) | (NUM_CLS'(1) << CLS_LINE_NUM);
endpackage

// File: rtl/vefc_class_filter.sv
module vefc_class_filter #(
   parameter int unsigned            N       = 12,
   parameter logic [N-1:0]           HD_ONLY = '0
) (
   input  logic [N-1:0] raw_i,
   input  logic         hd_i,
   output logic [N-1:0] valid_o
);
   if (N < 1) begin : g_bad_n
      $error("vefc_class_filter: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_cls
      if (HD_ONLY[i]) begin : g_hd
         assign valid_o[i] = raw_i[i] & hd_i;
      end else begin : g_any
         assign valid_o[i] = raw_i[i];
      end
   end
endmodule

// File: rtl/vefc_loss_timer.sv
module vefc_loss_timer #(
   parameter int unsigned TIMEOUT_CYC = 1000000,
   parameter int unsigned TICK_CYC    = 440000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   output logic lost_o,
   output logic tick_o
);
   localparam int unsigned SW = $clog2(TIMEOUT_CYC + 1);
   localparam int unsigned TW = $clog2(TICK_CYC + 1);

   if (TIMEOUT_CYC < 2) begin : g_bad_to
      $error("vefc_loss_timer: TIMEOUT_CYC must be at least 2");
   end
   if (TICK_CYC < 2) begin : g_bad_tk
      $error("vefc_loss_timer: TICK_CYC must be at least 2");
   end

   logic [SW-1:0] silence_q;
   logic [TW-1:0] tick_q;
   logic          lost_q;

   assign tick_o = lost_q && (tick_q == TW'(TICK_CYC - 1));
   assign lost_o = lost_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         silence_q <= '0;
         lost_q    <= 1'b0;
      end else if (strobe_i) begin
         silence_q <= '0;
         lost_q    <= 1'b0;
      end else if (!lost_q) begin
         silence_q <= silence_q + SW'(1);
         if (silence_q == SW'(TIMEOUT_CYC - 1)) lost_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                tick_q <= '0;
      else if (!lost_q || tick_o) tick_q <= '0;
      else                       tick_q <= tick_q + TW'(1);
   end

   // R9
   strobe_ends_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_i |=> !lost_o);
   // R8
   tick_needs_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> $past(lost_o));
endmodule

// File: rtl/vefc_sat_counter.sv
module vefc_sat_counter #(
   parameter int unsigned W        = 32,
   parameter bit          SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   if (W < 2) begin : g_bad_w
      $error("vefc_sat_counter: W must be at least 2");
   end

   logic [W-1:0] cnt_q, cnt_inc;

   if (SATURATE) begin : g_sat
      assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + W'(1);
   end else begin : g_wrap
      assign cnt_inc = cnt_q + W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else if (inc_i) cnt_q <= cnt_inc;
   end

   assign cnt_o = cnt_q;

   // R7
   clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_o == '0));
   // R4
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (cnt_o - $past(cnt_o)) <= W'(1));
   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SATURATE && !clr_i && cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));
endmodule

// File: rtl/vid_err_field_counter.sv
module vid_err_field_counter
   import vefc_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned TIMEOUT_CYC = 1000000,
   parameter int unsigned TICK_CYC    = 440000,
   parameter bit          SATURATE    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CLS-1:0]   err_pulse,
   input  logic                 field_strobe,
   input  logic                 hd_mode,
   input  logic [NUM_CLS-1:0]   count_en,
   input  logic                 hold_en,
   input  logic                 cnt_clear,
   output logic [NUM_CLS-1:0]   err_bits,
   output logic [CNT_W-1:0]     err_count
);
   localparam logic [NUM_CLS-1:0] LOCK_BIT = NUM_CLS'(1) << LOCK_IDX;

   if (LOCK_IDX >= NUM_CLS) begin : g_bad_lock
      $error("vid_err_field_counter: loss-of-lock index outside vector");
   end

   logic [NUM_CLS-1:0] cur_err, acc_q, bits_q, closing;
   logic               tick, lost, boundary, hit;

   vefc_class_filter #(.N(NUM_CLS), .HD_ONLY(HD_ONLY_MASK)) u_filter (
      .raw_i   (err_pulse),
      .hd_i    (hd_mode),
      .valid_o (cur_err)
   );

   vefc_loss_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .TICK_CYC(TICK_CYC)) u_loss (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (field_strobe),
      .lost_o   (lost),
      .tick_o   (tick)
   );

   assign boundary = field_strobe | tick;
   assign closing  = acc_q | cur_err | (tick ? LOCK_BIT : '0);
   assign hit      = boundary && !cnt_clear && |(closing & count_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         bits_q <= '0;
      end else if (cnt_clear) begin
         acc_q  <= '0;
         bits_q <= '0;
      end else if (boundary) begin
         acc_q  <= '0;
         bits_q <= hold_en ? (bits_q | closing) : closing;
      end else begin
         acc_q  <= acc_q | cur_err;
      end
   end

   assign err_bits = bits_q;

   vefc_sat_counter #(.W(CNT_W), .SATURATE(SATURATE)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (cnt_clear),
      .inc_i (hit),
      .cnt_o (err_count)
   );

   // R11
   bits_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!boundary && !cnt_clear) |=> $stable(err_bits));
   // R11
   count_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!boundary && !cnt_clear) |=> $stable(err_count));
   // R6
   hold_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_en && !cnt_clear) |=> ((err_bits & $past(err_bits)) == $past(err_bits)));
   // R8
   tick_flags_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_clear) |=> err_bits[LOCK_IDX]);
endmodule

// File: tb/tb_vid_err_field_counter.sv
module tb_vid_err_field_counter;
   localparam int CLK_PERIOD = 10;
   localparam int CW  = 4;
   localparam int TO  = 40;
   localparam int TK  = 16;
   localparam logic [11:0] HDM  = 12'h3A0;
   localparam logic [11:0] LOCK = 12'h010;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [11:0] err_pulse = '0, count_en = '0;
   logic field_strobe = 1'b0, hd_mode = 1'b1, hold_en = 1'b0, cnt_clear = 1'b0;
   logic [11:0] err_bits;
   logic [CW-1:0] err_count;

   int checks = 0, errors = 0;
   bit cmp_on = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vid_err_field_counter #(.CNT_W(CW), .TIMEOUT_CYC(TO), .TICK_CYC(TK)) dut (
      .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .field_strobe(field_strobe),
      .hd_mode(hd_mode), .count_en(count_en), .hold_en(hold_en),
      .cnt_clear(cnt_clear), .err_bits(err_bits), .err_count(err_count));

   // reference model built from the requirements
   logic [11:0] m_acc = '0, m_bits = '0, m_cur, m_clos;
   logic [CW-1:0] m_cnt = '0;
   int m_sil = 0, m_tcnt = 0;
   logic m_lost = 1'b0, m_tick, m_bnd, m_nlost;

   function automatic logic [11:0] filt(logic [11:0] e, logic hd);
      return hd ? e : (e & ~HDM);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_acc = '0; m_bits = '0; m_cnt = '0; m_sil = 0; m_tcnt = 0; m_lost = 1'b0;
      end else begin
         m_cur  = filt(err_pulse, hd_mode);
         m_tick = m_lost && (m_tcnt == TK - 1);
         m_bnd  = field_strobe | m_tick;
         m_clos = m_acc | m_cur | (m_tick ? LOCK : 12'h0);
         m_tcnt = (!m_lost || m_tick) ? 0 : m_tcnt + 1;
         if (field_strobe) begin
            m_sil = 0; m_nlost = 1'b0;
         end else begin
            m_nlost = m_lost | (m_sil == TO - 1);
            if (!m_lost) m_sil = m_sil + 1;
         end
         m_lost = m_nlost;
         if (cnt_clear) begin
            m_acc = '0; m_bits = '0; m_cnt = '0;
         end else if (m_bnd) begin
            if (|(m_clos & count_en) && m_cnt != {CW{1'b1}}) m_cnt = m_cnt + 1'b1;
            m_bits = hold_en ? (m_bits | m_clos) : m_clos;
            m_acc  = '0;
         end else begin
            m_acc = m_acc | m_cur;
         end
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) if (cmp_on) begin
      check("R4/R5/R6/R11 err_bits vs model", 32'(err_bits), 32'(m_bits));
      check("R3/R4/R10 err_count vs model", 32'(err_count), 32'(m_cnt));
   end

   task automatic cyc(int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic boundary(logic [11:0] e);
      err_pulse = e; field_strobe = 1'b1;
      cyc();
      err_pulse = '0; field_strobe = 1'b0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      cyc(3);
      check("reset err_bits", 32'(err_bits), 0);
      check("reset err_count", 32'(err_count), 0);
      rst_n = 1'b1;
      cyc();
      cmp_on = 1'b1;
      count_en = 12'hFFF;

      // R1: single class lands on its own bit
      err_pulse = 12'h008; cyc(); err_pulse = '0; cyc(2);
      boundary('0); cyc();
      check("R1 active-picture bit only", 32'(err_bits), 32'h008);
      check("R4 one step", 32'(err_count), 1);

      // R2: SD hides HD-only classes
      hd_mode = 1'b0;
      boundary(12'hFFF);
      check("R2 SD filter", 32'(err_bits), 32'h C5F);
      count_en = HDM;
      boundary(12'hFFF);
      check("R2 SD HD-only not counted", 32'(err_count), 2);
      hd_mode = 1'b1;

      // R3: masked error shows but does not count
      count_en = 12'h001;
      boundary(12'h800);
      check("R3 masked bit shown", 32'(err_bits), 32'h800);
      check("R3 masked not counted", 32'(err_count), 2);

      // R4: many pulses in one interval count once
      count_en = 12'hFFF;
      for (int i = 0; i < 5; i++) begin err_pulse = 12'h004; cyc(); end
      err_pulse = '0;
      boundary('0);
      check("R4 many pulses one count", 32'(err_count), 3);

      // R6: hold accumulates
      hold_en = 1'b1;
      boundary(12'h002);
      boundary(12'h400);
      check("R6 hold OR", 32'(err_bits), 32'h406);
      boundary('0);
      check("R6 hold kept", 32'(err_bits), 32'h406);
      hold_en = 1'b0;
      boundary('0);
      check("R5 normal replace", 32'(err_bits), 0);

      // R7: clear wins over boundary
      err_pulse = 12'h020; cyc();
      err_pulse = 12'h001; field_strobe = 1'b1; cnt_clear = 1'b1; cyc();
      err_pulse = '0; field_strobe = 1'b0; cnt_clear = 1'b0;
      check("R7 clear count", 32'(err_count), 0);
      check("R7 clear bits", 32'(err_bits), 0);
      boundary('0);
      check("R7 dropped errors", 32'(err_bits), 0);

      // R8: loss of input, fallback ticks with loss-of-lock
      cyc(TO + TK + 2);
      check("R8 lock bit on tick", 32'(err_bits), 32'(LOCK));
      check("R8 tick counted", 32'(err_count), 1);
      cyc(TK * 3);
      check("R8 ticks keep counting", 32'(err_count), 4);

      // R9: strobes return, no more ticks
      for (int i = 0; i < 8; i++) begin boundary('0); cyc(9); end
      check("R9 no lock after return", 32'(err_bits), 0);
      check("R9 count frozen", 32'(err_count), 4);

      // R10: saturation
      for (int i = 0; i < 20; i++) boundary(12'h200);
      check("R10 saturated", 32'(err_count), 32'hF);

      // random phase
      for (int i = 0; i < 6000; i++) begin
         err_pulse    = (($urandom % 6) == 0) ? 12'($urandom) : '0;
         field_strobe = (($urandom % 13) == 0);
         cnt_clear    = (($urandom % 150) == 0);
         if (($urandom % 400) == 0) begin
            hd_mode = 1'($urandom); hold_en = 1'($urandom); count_en = 12'($urandom);
         end
         if (($urandom % 1500) == 0) begin
            field_strobe = 1'b0; err_pulse = '0; cyc(TO + 3 * TK);
         end
         cyc();
      end
      err_pulse = '0; field_strobe = 1'b0; cnt_clear = 1'b0;
      cyc(2);
      cmp_on = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule